// File: doc/BRIEF.md
# Linked-Channel Buffered PWM Timer

A 16-bit up-counter, advanced once every `PRE_DIV` clocks by a built-in divider, counts from zero up to a programmable modulo value and then wraps to zero, which sets the PWM period. Two output-compare channels each own a compare value and a small configuration field. On its own, a channel acts on its pin when the count reaches its compare value, and it can also toggle the pin when the count wraps.

Setting the buffered mode on channel 0 links the two channels. Their compare values then take turns supplying the duty value to channel 0's pin, and they swap at every wrap. Software can therefore load the idle channel without glitching the period in progress. A 0% duty output comes from turning off the wrap toggle. A 100% duty output comes from a max-duty override. Neither one depends on the compare value.

Software drives everything through a single write port. That port carries a stop bit, a self-clearing counter reset, the modulo value, both compare values and both configuration fields.

Top module: `pwm_link_timer`

## Requirements
- R1: After reset the count is 0, the modulo is all ones, every configuration is 0 and all outputs are low. On each counter tick the count goes from its current value c to c+1, or to 0 when c equals the modulo. `ovf_flag` pulses high for one cycle in the cycle after each wrap.
- R2: A counter tick happens on every `PRE_DIV`-th clock while the counter runs. After a counter reset, the first tick comes `PRE_DIV` clocks later.
- R3: Writing address 0 with bit 0 set stops the counter. While stopped, the count and the divider keep their values. Writing bit 0 clear restarts them.
- R4: Writing address 0 with bit 1 set clears the count, the divider and the buffered-channel selector on that clock edge. No event happens on that edge. The bit does not stay set, and counting resumes on its own afterwards.
- R5: Address 1 holds the modulo, address 2 the channel-0 compare value and address 3 the channel-1 compare value. A compare event for a channel fires on the tick where the new count equals that channel's compare value. The action comes from config bits [3:2]: 10 drives the pin low, 11 drives it high, 01 toggles it and 00 does nothing. `cmp_flag[c]` pulses high in the cycle after channel c's compare value is reached.
- R6: Config bit 4 enables a toggle of the channel output at each wrap. With bit 4 clear, the output can only move to the compare level, which gives a 0% duty output.
- R7: With config bits 5 and 4 both set, each tick drives the channel output to the complement of config bit 2, which gives a 100% duty output.
- R8: When a compare event and a wrap toggle fall on the same tick (compare value 0), the compare action wins.
- R9: Config bits [1:0] select the mode. 00 holds the pin low, 01 selects unbuffered output compare, and bit 1 set selects buffered mode whatever the state of bit 0. Channel 0's configuration lives at address 4 and channel 1's at address 5.
- R10: In buffered mode on channel 0, channel 0's compare value is used first after a counter reset, and the channels swap at every wrap. Channel 0's configuration governs `pwm_pin[0]`, and `pwm_pin[1]` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 modulo, 2..3 compare, 4..5 config) |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| pwm_pin | output | 2 | Channel output pins |
| ovf_flag | output | 1 | One-cycle pulse after a wrap |
| cmp_flag | output | 2 | One-cycle pulse per channel after its compare value is reached |

## Verification
A write presented before a clock edge takes effect on that edge. The count, the pins and both flags reflect a tick one register stage after the edge where the tick occurs, so every result is due one clock after the stimulus that caused it. The bench drives inputs on the falling edge and advances its own model on the rising edge. It compares the outputs on the next falling edge, which is exactly one register stage later. Duty-cycle checks let one full period settle before they count high cycles over a whole number of periods.

// File: rtl/pwm_link_timer.sv
module pwm_link_timer #(
  parameter int CW = 16,
  parameter int PRE_DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] count,
  output logic [1:0]    pwm_pin,
  output logic          ovf_flag,
  output logic [1:0]    cmp_flag
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic stop, sel, sel_nx, tick, wrap, trst, buf_on, hit0;
  logic [PW-1:0] pre;
  logic [CW-1:0] cnt, modv, cnt_nx, act0;
  logic [1:0][CW-1:0] cmpv;
  logic [1:0][5:0] cfg;
  logic [1:0] outr, raw;

  assign trst   = wr_en && wr_addr == 3'd0 && wr_data[1];
  assign wrap   = tick && cnt == modv;
  assign cnt_nx = wrap ? '0 : cnt + 1'b1;
  assign buf_on = cfg[0][1];
  assign sel_nx = buf_on ? (sel ^ wrap) : 1'b0;
  assign act0   = (buf_on && sel_nx) ? cmpv[1] : cmpv[0];
  assign hit0   = tick && cnt_nx == act0;
  assign raw    = {tick && cnt_nx == cmpv[1], tick && cnt_nx == cmpv[0]};
  assign count  = cnt;
  assign pwm_pin[0] = (cfg[0][1:0] != 2'b00) && outr[0];
  assign pwm_pin[1] = !buf_on && (cfg[1][1:0] != 2'b00) && outr[1];

  generate
    if (PRE_DIV > 1) begin : g_div
      assign tick = !stop && pre == PW'(PRE_DIV - 1);
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pre <= '0;
        else if (trst) pre <= '0;
        else if (!stop) pre <= tick ? '0 : pre + 1'b1;
    end else begin : g_nodiv
      assign tick = !stop;
      assign pre = '0;
    end
  endgenerate

  function automatic logic ch_next(input logic o, input logic [5:0] c,
                                   input logic h, input logic w, input logic t);
    if (!t) return o;
    if (c[5] && c[4]) return ~c[2];
    if (h) begin
      case (c[3:2])
        2'b01:   return ~o;
        2'b10:   return 1'b0;
        2'b11:   return 1'b1;
        default: return o;
      endcase
    end
    if (w && c[4]) return ~o;
    return o;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop <= 1'b0; sel <= 1'b0; cnt <= '0; modv <= '1;
      cmpv <= '0; cfg <= '0; outr <= '0;
      ovf_flag <= 1'b0; cmp_flag <= '0;
    end else begin
      if (trst) begin
        cnt <= '0; sel <= 1'b0; ovf_flag <= 1'b0; cmp_flag <= '0;
      end else begin
        if (tick) cnt <= cnt_nx;
        sel      <= sel_nx;
        ovf_flag <= wrap;
        cmp_flag <= raw;
        outr[0]  <= ch_next(outr[0], cfg[0], hit0, wrap, tick);
        outr[1]  <= ch_next(outr[1], cfg[1], raw[1], wrap, tick);
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: stop <= wr_data[0];
          3'd1: modv <= wr_data;
          3'd2: cmpv[0] <= wr_data;
          3'd3: cmpv[1] <= wr_data;
          3'd4: cfg[0] <= wr_data[5:0];
          3'd5: cfg[1] <= wr_data[5:0];
          default: ;
        endcase
      end
    end
  end

  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !trst) |=> (count == '0 && ovf_flag));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !trst) |=> $stable(count));
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    trst |=> (count == '0 && pre == '0 && !ovf_flag));
  a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0] == 6'h09 && !pwm_pin[0] && !wr_en) |=> !pwm_pin[0]);
  a_r7_full: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cfg[0] == 6'h39 && !wr_en) |=> pwm_pin[0]);
  a_r8_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && cmpv[0] == '0 && cfg[0][5] == 1'b0 && cfg[0][3:0] == 4'b1001 && !wr_en)
      |=> !pwm_pin[0]);
endmodule

// File: tb/sim_pwm_link_timer.sv
module sim_pwm_link_timer;
  localparam int PERIOD = 10;
  localparam int DIV = 2;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic [1:0] pwm_pin, cmp_flag;
  logic ovf_flag;
  int checks = 0, errors = 0;

  // model state
  logic m_stop, m_sel, m_ovf;
  logic [15:0] m_cnt, m_mod;
  logic [1:0][15:0] m_cmp;
  logic [1:0][5:0] m_cfg;
  logic [1:0] m_out, m_cf;
  int m_pre;

  pwm_link_timer #(.CW(16), .PRE_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .pwm_pin(pwm_pin), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag));

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic f_next(input logic o, input logic [5:0] c,
                                  input logic h, input logic w, input logic t);
    if (!t) return o;
    if (c[5] && c[4]) return ~c[2];
    if (h) return (c[3:2] == 2'b01) ? ~o : (c[3:2] == 2'b10) ? 1'b0 :
                  (c[3:2] == 2'b11) ? 1'b1 : o;
    if (w && c[4]) return ~o;
    return o;
  endfunction

  function automatic logic [1:0] exp_pin();
    return {!m_cfg[0][1] && m_cfg[1][1:0] != 0 && m_out[1],
            m_cfg[0][1:0] != 0 && m_out[0]};
  endfunction

  task automatic model_step(input logic w, input logic [2:0] a, input logic [15:0] d);
    logic tk, wr, bon, sn;
    logic [15:0] nx, act;
    tk = !m_stop && (m_pre == DIV - 1);
    if (w && a == 0 && d[1]) begin
      m_cnt = 0; m_pre = 0; m_sel = 0; m_ovf = 0; m_cf = 0;
    end else begin
      wr = tk && m_cnt == m_mod;
      nx = wr ? 16'd0 : m_cnt + 16'd1;
      bon = m_cfg[0][1];
      sn = bon ? (m_sel ^ wr) : 1'b0;
      act = (bon && sn) ? m_cmp[1] : m_cmp[0];
      m_out[0] = f_next(m_out[0], m_cfg[0], tk && nx == act, wr, tk);
      m_out[1] = f_next(m_out[1], m_cfg[1], tk && nx == m_cmp[1], wr, tk);
      m_cf = {tk && nx == m_cmp[1], tk && nx == m_cmp[0]};
      m_ovf = wr;
      if (tk) m_cnt = nx;
      if (!m_stop) m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
      m_sel = sn;
    end
    if (w) case (a)
      3'd0: m_stop = d[0];
      3'd1: m_mod = d;
      3'd2: m_cmp[0] = d;
      3'd3: m_cmp[1] = d;
      3'd4: m_cfg[0] = d[5:0];
      3'd5: m_cfg[1] = d[5:0];
      default: ;
    endcase
  endtask

  task automatic cyc(input logic w, input logic [2:0] a, input logic [15:0] d);
    wr_en = w; wr_addr = a; wr_data = d;
    model_step(w, a, d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R1 count", count, m_cnt);
    chk("R1 ovf_flag", ovf_flag, m_ovf);
    chk("R5 cmp_flag", cmp_flag, m_cf);
    chk("R9 R10 pwm_pin", pwm_pin, exp_pin());
  endtask

  task automatic idle(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 3'd0, 16'd0);
      hi += pwm_pin[0];
    end
  endtask

  initial begin
    int hi, c0;
    void'($urandom(32'h5eed_1234));
    m_stop = 0; m_sel = 0; m_ovf = 0; m_cnt = 0; m_mod = 16'hffff;
    m_cmp = '0; m_cfg = '0; m_out = '0; m_cf = '0; m_pre = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset count", count, 0);
    chk("R1 reset pins", {pwm_pin, ovf_flag, cmp_flag}, 0);

    // R2 divider
    cyc(1'b1, 3'd0, 16'h0002);
    idle(7, hi);
    chk("R2 ticks every DIV clocks", count, 7 / DIV);
    // R3 stop holds
    cyc(1'b1, 3'd0, 16'h0001);
    c0 = count;
    idle(10, hi);
    chk("R3 stopped count held", count, c0);
    // R4 reset self-clears and counting resumes
    cyc(1'b1, 3'd0, 16'h0002);
    chk("R4 count cleared", count, 0);
    idle(2 * DIV, hi);
    chk("R4 counting resumes", count, 2);

    cyc(1'b1, 3'd1, 16'd9);
    cyc(1'b1, 3'd2, 16'd3);
    // R6 zero duty
    cyc(1'b1, 3'd4, 16'h0009);
    idle(20 * DIV, hi);
    idle(20 * DIV, hi);
    chk("R6 zero duty high cycles", hi, 0);
    // R7 full duty
    cyc(1'b1, 3'd4, 16'h0039);
    idle(20 * DIV, hi);
    idle(20 * DIV, hi);
    chk("R7 full duty high cycles", hi, 20 * DIV);
    // R8 compare at zero beats wrap toggle
    cyc(1'b1, 3'd2, 16'd0);
    cyc(1'b1, 3'd4, 16'h0019);
    idle(20 * DIV, hi);
    idle(20 * DIV, hi);
    chk("R8 compare wins over toggle", hi, 0);
    // R9 mode 00 holds pin low
    cyc(1'b1, 3'd4, 16'h0038);
    idle(20 * DIV, hi);
    chk("R9 mode off pin low", hi, 0);
    // R10 buffered: alternating 3 and 7 tick pulses, ch1 pin low
    cyc(1'b1, 3'd2, 16'd3);
    cyc(1'b1, 3'd3, 16'd7);
    cyc(1'b1, 3'd5, 16'h0039);
    cyc(1'b1, 3'd4, 16'h001b);
    cyc(1'b1, 3'd0, 16'h0002);
    idle(20 * DIV, hi);
    idle(20 * DIV, hi);
    chk("R10 buffered high cycles", hi, 10 * DIV);
    chk("R10 linked ch1 pin low", pwm_pin[1], 0);

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        logic [2:0] a;
        logic [15:0] d;
        a = 3'($urandom_range(0, 5));
        case (a)
          3'd0: d = {14'd0, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0)};
          3'd1: d = 16'($urandom_range(0, 23));
          3'd2, 3'd3: d = 16'($urandom_range(0, 25));
          default: d = 16'($urandom_range(0, 63));
        endcase
        cyc(1'b1, a, d);
      end else cyc(1'b0, 3'd0, 16'd0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule